// File: doc/BRIEF.md
# Dual-Processor Interrupt Request Controller

This block collects interrupt requests from peripheral sources and delivers them to one of two processors. Each processor owns a private set of state: a pending-flag word with one bit per source, an enable word of the same width, and a single global-enable bit. A peripheral raises a request by presenting a processor number and a source number for one cycle. The controller records the pending bit in the addressed set unconditionally. If that source is enabled and the global enable of that set is on, the request also counts as delivered.

Each processor sees a level interrupt output and a waiting indication. The interrupt output stays high while any pending bit is also enabled and the global enable is on. A processor parks itself in the waiting state with a one-cycle halt strobe. It is released on the first request that is delivered to it after that. Software reaches all registers through one write port and one combinational read port, both addressed by processor number and a register selector. Pending flags are cleared by writing ones.

Top module: `dual_irq_ctl`

## Requirements
- R1: A valid request for processor c and source s sets bit s of processor c's pending word on the next clock edge, whatever the enable word and global enable hold.
- R2: irq_out[c] is 1 exactly when processor c's global enable is 1 and some bit is 1 in both its pending word and its enable word.
- R3: A request that is delivered releases processor c from waiting on the next edge. A request is delivered when it is valid, addressed to c, its source bit is set in c's enable word, and c's global enable is 1.
- R4: Processor number 0 addresses the first register set and 1 the second. Requests and register writes that carry any other number change nothing. Reads with any other number return zero.
- R5: Writing to selector 0 (pending) clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R6: When a request and a pending-clear for the same bit fall in the same cycle, the bit ends up set.
- R7: A pulse on halt_strobe[c] makes waiting[c] 1 on the next edge, unless a delivered request for c arrives in the same cycle. A request that is not delivered leaves waiting[c] at 1.
- R8: After reset, all pending, enable, global-enable and waiting state is 0, and both irq_out bits are 0.
- R9: Selector 1 writes and reads the enable word. Selector 2 writes and reads the global enable in bit 0, and the upper bits read as 0. Selector 0 reads the pending word. Selector 3 reads as zero and its writes change nothing.
- R10: Requests, writes and halts addressed to one processor leave the other processor's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_cpu | input | ID_W | Processor number of the request |
| req_src | input | SRC_W | Source number of the request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_cpu | input | ID_W | Processor number for register read and write |
| reg_sel | input | 2 | Register selector: 0 pending, 1 enable, 2 global enable, 3 none |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rd_data | output | NUM_SRC | Combinational read data |
| halt_strobe | input | NUM_CPU | Per-processor request to enter the waiting state |
| irq_out | output | NUM_CPU | Per-processor interrupt level |
| waiting | output | NUM_CPU | Per-processor waiting state |

## Verification
The bench uses the default parameters: 32 sources, two processors and a 2-bit processor number. The 2-bit number lets the bench drive the unused numbers 2 and 3 on both the request port and the register port, so the ignore rule is exercised. The full 32-bit words let it reach the top source bit 31 and the all-ones clear pattern. A random phase drives requests, clears, halts and writes against a behavioural reference that is compared every cycle. This mixes same-cycle request and clear collisions and halt and wake collisions across both processors.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    SEL_PEND   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_GLOBAL = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_CPU = 2,
  parameter int NUM_SRC = 32,
  parameter int ID_W    = 2,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_cpu,
  input  logic [SRC_W-1:0]   req_src,
  input  logic               reg_wr_en,
  input  logic [ID_W-1:0]    reg_cpu,
  output logic [NUM_CPU-1:0] hit_vec,
  output logic [NUM_CPU-1:0] wsel_vec
);

  function automatic logic src_ok(input logic [SRC_W-1:0] s);
    return ({1'b0, s} < (SRC_W+1)'(NUM_SRC));
  endfunction

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_dec
    assign hit_vec[c]  = req_valid && (req_cpu == ID_W'(c)) && src_ok(req_src);
    assign wsel_vec[c] = reg_wr_en && (reg_cpu == ID_W'(c));
  end

endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [SRC_W-1:0]   src,
  input  logic               wr,
  input  logic [1:0]         sel,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic               gen_q,
  output logic               irq,
  output logic               deliver
);

  function automatic logic [NUM_SRC-1:0] one_hot(input logic [SRC_W-1:0] s);
    return NUM_SRC'(1) << s;
  endfunction

  function automatic logic [NUM_SRC-1:0] pend_next(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] clr,
    input logic [NUM_SRC-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  logic [NUM_SRC-1:0] set_mask;
  logic [NUM_SRC-1:0] clr_mask;

  assign set_mask = hit ? one_hot(src) : '0;
  assign clr_mask = (wr && sel == SEL_PEND) ? wdata : '0;
  assign deliver  = hit && gen_q && en_q[src];
  assign irq      = gen_q && (|(pend_q & en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      gen_q  <= 1'b0;
    end else begin
      pend_q <= pend_next(pend_q, clr_mask, set_mask);
      if (wr && sel == SEL_ENABLE) en_q  <= wdata;
      if (wr && sel == SEL_GLOBAL) gen_q <= wdata[0];
    end
  end

endmodule

// File: rtl/irq_wait.sv
module irq_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic wake,
  output logic wait_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wait_q <= 1'b0;
    else if (wake) wait_q <= 1'b0;
    else if (halt) wait_q <= 1'b1;
  end

endmodule

// File: rtl/dual_irq_ctl.sv
module dual_irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 2,
  parameter int ID_W    = 2,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_cpu,
  input  logic [SRC_W-1:0]   req_src,
  input  logic               reg_wr_en,
  input  logic [ID_W-1:0]    reg_cpu,
  input  logic [1:0]         reg_sel,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rd_data,
  input  logic [NUM_CPU-1:0] halt_strobe,
  output logic [NUM_CPU-1:0] irq_out,
  output logic [NUM_CPU-1:0] waiting
);

  logic [NUM_CPU-1:0]              hit_vec;
  logic [NUM_CPU-1:0]              wsel_vec;
  logic [NUM_CPU-1:0]              wake_vec;
  logic [NUM_CPU-1:0]              gen_all;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] pend_all;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] en_all;

  irq_route #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_route (
    .req_valid (req_valid),
    .req_cpu   (req_cpu),
    .req_src   (req_src),
    .reg_wr_en (reg_wr_en),
    .reg_cpu   (reg_cpu),
    .hit_vec   (hit_vec),
    .wsel_vec  (wsel_vec)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_vec[c]),
      .src     (req_src),
      .wr      (wsel_vec[c]),
      .sel     (reg_sel),
      .wdata   (reg_wdata),
      .pend_q  (pend_all[c]),
      .en_q    (en_all[c]),
      .gen_q   (gen_all[c]),
      .irq     (irq_out[c]),
      .deliver (wake_vec[c])
    );

    irq_wait u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt   (halt_strobe[c]),
      .wake   (wake_vec[c]),
      .wait_q (waiting[c])
    );
  end

  function automatic logic [NUM_SRC-1:0] pick(
    input logic [1:0]         s,
    input logic [NUM_SRC-1:0] p,
    input logic [NUM_SRC-1:0] e,
    input logic               g
  );
    case (s)
      SEL_PEND:   return p;
      SEL_ENABLE: return e;
      SEL_GLOBAL: return NUM_SRC'(g);
      default:    return '0;
    endcase
  endfunction

  always_comb begin
    reg_rd_data = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (reg_cpu == ID_W'(c))
        reg_rd_data = pick(reg_sel, pend_all[c], en_all[c], gen_all[c]);
    end
  end

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 2,
  parameter int ID_W    = 2,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic [ID_W-1:0]                 req_cpu,
  input logic [SRC_W-1:0]                req_src,
  input logic [NUM_CPU-1:0]              halt_strobe,
  input logic [NUM_CPU-1:0]              irq_out,
  input logic [NUM_CPU-1:0]              waiting,
  input logic [NUM_CPU-1:0]              hit_vec,
  input logic [NUM_CPU-1:0]              wake_vec,
  input logic [NUM_CPU-1:0]              gen_all,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] pend_all,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] en_all
);

  assert_route_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_bad_id_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cpu >= ID_W'(NUM_CPU)) |-> (hit_vec == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_req_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[c] |=> pend_all[c][$past(req_src)]);

    assert_irq_needs_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_all[c] |-> !irq_out[c]);

    assert_irq_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[c] |-> (|(pend_all[c] & en_all[c])));

    assert_wake_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vec[c] |=> !waiting[c]);

    assert_wait_from_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(waiting[c]) |-> $past(halt_strobe[c]));
  end

endmodule

bind dual_irq_ctl irq_ctl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_cpu     (req_cpu),
  .req_src     (req_src),
  .halt_strobe (halt_strobe),
  .irq_out     (irq_out),
  .waiting     (waiting),
  .hit_vec     (hit_vec),
  .wake_vec    (wake_vec),
  .gen_all     (gen_all),
  .pend_all    (pend_all),
  .en_all      (en_all)
);

// File: tb/dual_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module dual_irq_ctl_tb_top;

  localparam int NS = 32;
  localparam int NC = 2;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_cpu = '0;
  logic [4:0]    req_src = '0;
  logic          reg_wr_en = 1'b0;
  logic [IW-1:0] reg_cpu = '0;
  logic [1:0]    reg_sel = '0;
  logic [NS-1:0] reg_wdata = '0;
  logic [NS-1:0] reg_rd_data;
  logic [NC-1:0] halt_strobe = '0;
  logic [NC-1:0] irq_out;
  logic [NC-1:0] waiting;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_irq_ctl #(.NUM_SRC(NS), .NUM_CPU(NC), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cpu(req_cpu), .req_src(req_src),
    .reg_wr_en(reg_wr_en), .reg_cpu(reg_cpu), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data),
    .halt_strobe(halt_strobe), .irq_out(irq_out), .waiting(waiting)
  );

  // behavioural reference
  logic [31:0] m_pend [NC];
  logic [31:0] m_en   [NC];
  bit          m_gen  [NC];
  bit          m_wait [NC];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_pend[c] <= 0; m_en[c] <= 0; m_gen[c] <= 0; m_wait[c] <= 0;
      end
    end else begin
      for (int c = 0; c < NC; c++) begin
        logic [31:0] clr;
        bit mine_req, mine_wr, woke;
        mine_req = req_valid && (int'(req_cpu) == c);
        mine_wr  = reg_wr_en && (int'(reg_cpu) == c);
        clr = (mine_wr && reg_sel == 2'd0) ? reg_wdata : 32'h0;
        woke = mine_req && m_en[c][req_src] && m_gen[c];
        m_pend[c] <= (m_pend[c] & ~clr) | (mine_req ? (32'h1 << req_src) : 32'h0);
        if (mine_wr && reg_sel == 2'd1) m_en[c] <= reg_wdata;
        if (mine_wr && reg_sel == 2'd2) m_gen[c] <= reg_wdata[0];
        if (woke) m_wait[c] <= 0;
        else if (halt_strobe[c]) m_wait[c] <= 1;
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    int c;
    c = int'(reg_cpu);
    if (c >= NC) return 0;
    case (reg_sel)
      2'd0: return m_pend[c];
      2'd1: return m_en[c];
      2'd2: return {31'h0, m_gen[c]};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NC; c++) begin
        chk("R2 irq level", {31'h0, irq_out[c]},
            {31'h0, m_gen[c] && ((m_pend[c] & m_en[c]) != 0)});
        chk("R3 R7 waiting", {31'h0, waiting[c]}, {31'h0, m_wait[c]});
      end
      chk("R9 read port", reg_rd_data, exp_rd());
    end
  end

  task automatic step();
    @(negedge clk); #1;
    req_valid = 0; reg_wr_en = 0; halt_strobe = '0;
  endtask

  task automatic req(input int cpu, input int src);
    req_valid = 1; req_cpu = IW'(cpu); req_src = 5'(src);
  endtask

  task automatic wr(input int cpu, input int sel, input logic [31:0] d);
    reg_wr_en = 1; reg_cpu = IW'(cpu); reg_sel = 2'(sel); reg_wdata = d;
  endtask

  task automatic rd(input int cpu, input int sel, output logic [31:0] d);
    reg_cpu = IW'(cpu); reg_sel = 2'(sel); #1; d = reg_rd_data;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < 3; s++) begin
        rd(c, s, d); chk("R8 reset reg", d, 0);
      end
    end
    chk("R8 reset irq", {30'h0, irq_out}, 0);
    chk("R8 reset waiting", {30'h0, waiting}, 0);
    rst_n = 1;
    step();

    // R1 latch without enable
    req(0, 5); step();
    rd(0, 0, d); chk("R1 flag latched while disabled", d, 32'h20);
    chk("R2 no irq when disabled", {31'h0, irq_out[0]}, 0);

    // R2 / R9 enable then global
    wr(0, 1, 32'h20); step();
    rd(0, 1, d); chk("R9 enable readback", d, 32'h20);
    chk("R2 no irq without global", {31'h0, irq_out[0]}, 0);
    wr(0, 2, 32'hFFFF_FFFF); step();
    rd(0, 2, d); chk("R9 global reads bit0 only", d, 32'h1);
    chk("R2 irq asserted", {31'h0, irq_out[0]}, 1);
    chk("R10 other cpu quiet", {31'h0, irq_out[1]}, 0);

    // R5 write-one-to-clear
    wr(0, 0, 32'h0); step();
    rd(0, 0, d); chk("R5 zero write keeps flag", d, 32'h20);
    wr(0, 0, 32'h20); step();
    rd(0, 0, d); chk("R5 one write clears", d, 0);
    chk("R2 irq drops after clear", {31'h0, irq_out[0]}, 0);

    // R6 collision
    req(0, 7); wr(0, 0, 32'hFFFF_FFFF); step();
    rd(0, 0, d); chk("R6 request beats clear", d, 32'h80);
    wr(0, 0, 32'h80); step();

    // R9 selector 3
    wr(0, 3, 32'hFFFF_FFFF); step();
    rd(0, 3, d); chk("R9 selector 3 reads zero", d, 0);
    rd(0, 1, d); chk("R9 selector 3 write ignored", d, 32'h20);

    // R7 halt, non-delivered request does not wake
    halt_strobe = 2'b10; step();
    chk("R7 halt enters waiting", {31'h0, waiting[1]}, 1);
    chk("R10 cpu0 not waiting", {31'h0, waiting[0]}, 0);
    req(1, 31); step();
    chk("R7 disabled request keeps waiting", {31'h0, waiting[1]}, 1);
    rd(1, 0, d); chk("R1 bit 31 latched", d, 32'h8000_0000);
    wr(1, 1, 32'h8000_0000); step();
    wr(1, 2, 32'h1); step();
    chk("R7 enable alone does not wake", {31'h0, waiting[1]}, 1);
    req(1, 31); step();
    chk("R3 delivered request wakes", {31'h0, waiting[1]}, 0);
    // R7 halt and wake same cycle: wake wins
    halt_strobe = 2'b10; req(1, 31); step();
    chk("R7 wake wins over halt", {31'h0, waiting[1]}, 0);

    // R4 ignored ids
    req(2, 3); step();
    req(3, 4); step();
    wr(2, 1, 32'hFFFF_FFFF); step();
    wr(3, 2, 32'h1); step();
    rd(0, 0, d); chk("R4 id 2/3 request ignored cpu0", d, 0);
    rd(1, 0, d); chk("R4 id 2/3 request ignored cpu1", d, 32'h8000_0000);
    rd(0, 1, d); chk("R4 id 2/3 write ignored", d, 32'h20);
    rd(2, 1, d); chk("R4 id 2 reads zero", d, 0);
    rd(0, 0, d); chk("R10 cpu1 traffic left cpu0", d, 0);

    // random phase, compared each cycle by the reference
    for (int i = 0; i < 2000; i++) begin
      req_valid = ($urandom % 3) == 0;
      req_cpu = IW'($urandom % 4);
      req_src = 5'($urandom % 32);
      reg_wr_en = ($urandom % 5) == 0;
      reg_cpu = IW'($urandom % 4);
      reg_sel = 2'($urandom % 4);
      reg_wdata = $urandom;
      halt_strobe = 2'($urandom % 4);
      @(negedge clk); #1;
    end
    req_valid = 0; reg_wr_en = 0; halt_strobe = '0;
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule